// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits between a host bus and the embedded program/erase engine of a NOR-style flash macro. Each time the host starts a write cycle, the block decodes the command byte and the command address. From them it builds the operating mode that governs reads (array, device identification, query table, lock verification). It also fires one-cycle start pulses to the engine, with the target address and data latched alongside.

The interpreter tracks multi-cycle unlock sequences for program, sector and chip erase, a two-cycle fast-program mode, erase suspend and resume, and an overlay mode. The overlay maps a small security region over the lowest word addresses. Accelerated programming is requested by an input level and is withheld while the overlay is active. A byte/word select chooses how command addresses are read off the bus. In byte mode the least significant address bit is dropped before decoding.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write is taken only on the first clock where ce_n=0, we_n=0 and oe_n=1 all hold, after a clock where they did not. Every other strobe combination is inhibited and has no effect.
- R2: Data AAh at word address 555h, then 55h at 2AAh, then A0h at 555h, then any address/data starts a program. pg_go is high for one cycle after the fourth write, with op_addr and op_data holding that write's bus values. In byte mode the command addresses are AAAh, 554h and AAAh.
- R3: 98h written to word address 55h (byte address AAh), from mode 0 (array) or mode 1 (identify), enters mode 2 (query). It is ignored while busy is high. In mode 2 every write except F0h is ignored, and F0h returns the mode to 0.
- R4: The unlock pair followed by 90h at 555h enters mode 1. F0h returns the mode to 0.
- R5: The unlock pair, 80h at 555h, and the unlock pair again are followed by one of two writes. 30h at any address gives er_go with er_all=0 and that address on op_addr. 10h at 555h gives er_go with er_all=1.
- R6: The unlock pair followed by 20h at 555h sets byp_act. While it is set, A0h and then address/data programs in two writes. 90h followed by 00h clears it. acc_req=1 forces byp_act=1 and acc_en=1.
- R7: The unlock pair followed by 88h at 555h sets sec_on. region_sel equals sec_on AND (word address < 128). The unlock pair, 90h at 555h and then 00h clears sec_on. While sec_on=1, byp_act and acc_en stay 0 and the fast-program entry is ignored.
- R8: With sec_on=1, writing 60h and then 40h at a word address with A6=0, A1=1, A0=0 enters mode 3. In mode 3, vfy_q = {7'b0, lock_in} when the bus address matches that pattern, and 00h otherwise. 40h at any other address returns the mode to 0.
- R9: B0h written while busy=1 during an erase gives sus_go. 30h written while suspended gives res_go. B0h during a program gives nothing.
- R10: While busy=1, every write except an erase-suspend is ignored. A falling edge of busy that is not caused by a suspend returns the mode to 0.
- R11: A write that breaks an expected sequence returns the mode to 0 and drops the partial sequence.
- R12: rst_n low returns the mode to 0, clears sec_on and the fast-program mode, and drops any partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up and hardware reset) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1: byte addressing, bit 0 of addr is the byte select |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data; the command byte is din[7:0] |
| busy | input | 1 | Embedded algorithm running |
| acc_req | input | 1 | Accelerated programming requested |
| lock_in | input | 1 | Lock state of the security region |
| mode | output | 2 | 0 array, 1 identify, 2 query, 3 lock verify |
| sec_on | output | 1 | Security overlay active |
| byp_act | output | 1 | Two-cycle program mode active |
| acc_en | output | 1 | Acceleration granted |
| region_sel | output | 1 | Current address falls in the overlaid region |
| vfy_q | output | 8 | Lock verify read value |
| pg_go | output | 1 | Program start pulse |
| er_go | output | 1 | Erase start pulse |
| er_all | output | 1 | Erase is whole-chip (valid with er_go) |
| sus_go | output | 1 | Erase suspend pulse |
| res_go | output | 1 | Erase resume pulse |
| op_addr | output | AW | Latched operation address |
| op_data | output | DW | Latched operation data |

## Verification
All eight strobe combinations are tried on the final program write. Only the one legal combination may produce a program pulse, which separates a correct write qualifier from one that ignores a strobe. Sequences are run in both byte and word addressing, which shows whether the command address is normalised. A sweep across the lowest few hundred word addresses with the overlay active pins the region boundary. Broken sequences, writes during busy, and commands entered from the identify and verify modes show which writes are honoured and which are dropped.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [1:0] {
    M_READ = 2'd0,
    M_AUTO = 2'd1,
    M_CFI  = 2'd2,
    M_VFY  = 2'd3
  } mode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3, S_XIT, S_BX, S_V1
  } seq_t;

  localparam int KEY_W = 11;
  localparam logic [KEY_W-1:0] K_UNL1 = 11'h555;
  localparam logic [KEY_W-1:0] K_UNL2 = 11'h2AA;
  localparam logic [KEY_W-1:0] K_QRY  = 11'h055;

  // lock verify address pattern: A6 low, A1 high, A0 low
  function automatic logic vfy_pat(input logic a6, input logic [1:0] a10);
    return (a6 == 1'b0) && (a10 == 2'b10);
  endfunction

  // the first unlock cycle of any sequence
  function automatic logic is_unl1(input logic [KEY_W-1:0] k, input logic [7:0] c);
    return (k == K_UNL1) && (c == 8'hAA);
  endfunction

  function automatic logic is_unl2(input logic [KEY_W-1:0] k, input logic [7:0] c);
    return (k == K_UNL2) && (c == 8'h55);
  endfunction

endpackage

// File: rtl/fci_strobe.sv
module fci_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic busy,
  output logic wr_acc,
  output logic done
);
  logic wr_q, busy_q;
  logic wr_now;

  assign wr_now = !ce_n && !we_n && oe_n;
  assign wr_acc = wr_now && !wr_q;
  assign done   = busy_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      wr_q   <= wr_now;
      busy_q <= busy;
    end
  end
endmodule

// File: rtl/fci_region.sv
module fci_region #(
  parameter int AW        = 23,
  parameter int SEC_WORDS = 128
) (
  input  logic              byte_mode,
  input  logic [AW-1:0]     addr,
  input  logic              sec_on,
  input  fci_pkg::mode_t    mode,
  input  logic              lock_in,
  output logic [10:0]       key,
  output logic              vfy_hit,
  output logic              region_sel,
  output logic [7:0]        vfy_q
);
  import fci_pkg::*;
  localparam int WA = AW - 1;
  localparam int SW = $clog2(SEC_WORDS);

  logic [WA-1:0] wa;

  assign wa         = byte_mode ? addr[AW-1:1] : addr[AW-2:0];
  assign key        = wa[10:0];
  assign vfy_hit    = vfy_pat(wa[6], wa[1:0]);
  assign region_sel = sec_on && ((wa >> SW) == '0);
  assign vfy_q      = (mode == M_VFY && vfy_hit) ? {7'b0, lock_in} : 8'h00;
endmodule

// File: rtl/fci_seq.sv
module fci_seq (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_acc,
  input  logic           done,
  input  logic           busy,
  input  logic           acc_req,
  input  logic [7:0]     cmd,
  input  logic [10:0]    key,
  input  logic           vfy_hit,
  output fci_pkg::mode_t mode,
  output logic           sec_on,
  output logic           byp_act,
  output logic           acc_en,
  output logic           susp,
  output logic           pg_go,
  output logic           er_go,
  output logic           er_all,
  output logic           sus_go,
  output logic           res_go,
  output logic           cap
);
  import fci_pkg::*;

  mode_t mode_q, n_mode;
  seq_t  seq_q,  n_seq;
  logic  sec_q, n_sec, byp_q, n_byp, susp_q, n_susp, ers_q, n_ers;
  logic  n_pg, n_er, n_all, n_sus, n_res;

  assign mode    = mode_q;
  assign sec_on  = sec_q;
  assign susp    = susp_q;
  assign acc_en  = acc_req && !sec_q;
  assign byp_act = (byp_q || acc_req) && !sec_q;

  always_comb begin
    n_mode = mode_q; n_seq = seq_q; n_sec = sec_q; n_byp = byp_q;
    n_susp = susp_q; n_ers = ers_q;
    n_pg = 1'b0; n_er = 1'b0; n_all = 1'b0; n_sus = 1'b0; n_res = 1'b0;
    cap  = 1'b0;
    if (wr_acc) begin
      if (busy) begin
        if (cmd == 8'hB0 && ers_q && !susp_q) begin
          n_sus = 1'b1; n_susp = 1'b1;
        end
      end else if (mode_q == M_CFI) begin
        if (cmd == 8'hF0) begin n_mode = M_READ; n_seq = S_IDLE; end
      end else if (seq_q == S_XIT && cmd == 8'h00) begin
        n_sec = 1'b0; n_mode = M_READ; n_seq = S_IDLE;
      end else begin
        case (seq_q)
          S_IDLE, S_XIT: begin
            n_seq = S_IDLE;
            if (byp_act) begin
              if (cmd == 8'hA0)      n_seq = S_PGM;
              else if (cmd == 8'h90) n_seq = S_BX;
            end else if (is_unl1(key, cmd)) n_seq = S_U1;
            else if (cmd == 8'hF0) n_mode = M_READ;
            else if (cmd == 8'h98 && key == K_QRY &&
                     (mode_q == M_READ || mode_q == M_AUTO)) n_mode = M_CFI;
            else if (cmd == 8'h30 && susp_q) begin n_res = 1'b1; n_susp = 1'b0; end
            else if (cmd == 8'h60 && sec_q) n_seq = S_V1;
            else n_mode = M_READ;
          end
          S_U1: begin
            n_seq = is_unl2(key, cmd) ? S_U2 : S_IDLE;
            if (!is_unl2(key, cmd)) n_mode = M_READ;
          end
          S_U2: begin
            n_seq = S_IDLE;
            if (key != K_UNL1) n_mode = M_READ;
            else case (cmd)
              8'hA0: n_seq = S_PGM;
              8'h80: n_seq = S_E1;
              8'h20: n_byp = !sec_q;
              8'h88: n_sec = 1'b1;
              8'h90: begin n_mode = M_AUTO; n_seq = S_XIT; end
              default: n_mode = M_READ;
            endcase
          end
          S_PGM: begin n_pg = 1'b1; cap = 1'b1; n_seq = S_IDLE; end
          S_E1: begin
            n_seq = is_unl1(key, cmd) ? S_E2 : S_IDLE;
            if (!is_unl1(key, cmd)) n_mode = M_READ;
          end
          S_E2: begin
            n_seq = is_unl2(key, cmd) ? S_E3 : S_IDLE;
            if (!is_unl2(key, cmd)) n_mode = M_READ;
          end
          S_E3: begin
            n_seq = S_IDLE;
            if (cmd == 8'h30) begin
              n_er = 1'b1; cap = 1'b1; n_ers = 1'b1;
            end else if (cmd == 8'h10 && key == K_UNL1) begin
              n_er = 1'b1; n_all = 1'b1; cap = 1'b1; n_ers = 1'b1;
            end else n_mode = M_READ;
          end
          S_BX: begin
            n_seq = S_IDLE;
            if (cmd == 8'h00) n_byp = 1'b0;
          end
          S_V1: begin
            n_seq  = S_IDLE;
            n_mode = (cmd == 8'h40 && vfy_hit) ? M_VFY : M_READ;
          end
          default: begin n_seq = S_IDLE; n_mode = M_READ; end
        endcase
      end
    end
    if (done && !susp_q) begin
      n_mode = M_READ; n_ers = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_READ; seq_q <= S_IDLE; sec_q <= 1'b0; byp_q <= 1'b0;
      susp_q <= 1'b0; ers_q <= 1'b0;
      pg_go <= 1'b0; er_go <= 1'b0; er_all <= 1'b0; sus_go <= 1'b0; res_go <= 1'b0;
    end else begin
      mode_q <= n_mode; seq_q <= n_seq; sec_q <= n_sec; byp_q <= n_byp;
      susp_q <= n_susp; ers_q <= n_ers;
      pg_go <= n_pg; er_go <= n_er; er_all <= n_all; sus_go <= n_sus; res_go <= n_res;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int SEC_WORDS = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          byte_mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          busy,
  input  logic          acc_req,
  input  logic          lock_in,
  output logic [1:0]    mode,
  output logic          sec_on,
  output logic          byp_act,
  output logic          acc_en,
  output logic          region_sel,
  output logic [7:0]    vfy_q,
  output logic          pg_go,
  output logic          er_go,
  output logic          er_all,
  output logic          sus_go,
  output logic          res_go,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  import fci_pkg::*;

  logic          wr_acc, done, susp, cap, vfy_hit;
  logic [10:0]   key;
  mode_t         mode_e;

  assign mode = mode_e;

  fci_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .busy(busy), .wr_acc(wr_acc), .done(done)
  );

  fci_region #(.AW(AW), .SEC_WORDS(SEC_WORDS)) u_region (
    .byte_mode(byte_mode), .addr(addr), .sec_on(sec_on), .mode(mode_e),
    .lock_in(lock_in), .key(key), .vfy_hit(vfy_hit),
    .region_sel(region_sel), .vfy_q(vfy_q)
  );

  fci_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .done(done), .busy(busy),
    .acc_req(acc_req), .cmd(din[7:0]), .key(key), .vfy_hit(vfy_hit),
    .mode(mode_e), .sec_on(sec_on), .byp_act(byp_act), .acc_en(acc_en),
    .susp(susp), .pg_go(pg_go), .er_go(er_go), .er_all(er_all),
    .sus_go(sus_go), .res_go(res_go), .cap(cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr <= '0;
      op_data <= '0;
    end else if (cap) begin
      op_addr <= addr;
      op_data <= din;
    end
  end
endmodule

// File: rtl/fci_chk.sv
module fci_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_acc,
  input logic       done,
  input logic       susp,
  input logic       busy,
  input logic [1:0] mode,
  input logic       sec_on,
  input logic       byp_act,
  input logic       acc_en,
  input logic       region_sel,
  input logic       pg_go,
  input logic       er_go,
  input logic       sus_go,
  input logic       res_go
);
  // R1: every start pulse is the result of an accepted write
  p_go_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_go || er_go || sus_go || res_go) |-> $past(wr_acc));

  // R2: at most one engine request at a time
  p_one_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pg_go, er_go, sus_go, res_go}));

  // R3: query mode is never entered through a write taken while busy
  p_query_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> !$past(busy));

  // R7: overlay excludes fast program and acceleration
  p_overlay_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_on |-> (!byp_act && !acc_en));

  // R7: region select only while the overlay is active
  p_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel |-> sec_on);

  // R10: completion returns to array mode
  p_done_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !susp) |=> (mode == 2'd0));
endmodule

bind flash_cmd_seq fci_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .done(done), .susp(susp),
  .busy(busy), .mode(mode), .sec_on(sec_on), .byp_act(byp_act),
  .acc_en(acc_en), .region_sel(region_sel), .pg_go(pg_go), .er_go(er_go),
  .sus_go(sus_go), .res_go(res_go)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic busy = 1'b0, acc_req = 1'b0, lock_in = 1'b0;
  logic [1:0] mode;
  logic sec_on, byp_act, acc_en, region_sel, pg_go, er_go, er_all, sus_go, res_go;
  logic [7:0] vfy_q;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int n_chk = 0, n_fail = 0;
  logic s_pg, s_er, s_all, s_sus, s_res;

  always #5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW), .SEC_WORDS(128)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .addr(addr), .din(din), .busy(busy),
    .acc_req(acc_req), .lock_in(lock_in), .mode(mode), .sec_on(sec_on),
    .byp_act(byp_act), .acc_en(acc_en), .region_sel(region_sel),
    .vfy_q(vfy_q), .pg_go(pg_go), .er_go(er_go), .er_all(er_all),
    .sus_go(sus_go), .res_go(res_go), .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] phys(input logic [AW-2:0] wa);
    return byte_mode ? {wa, 1'b0} : {1'b0, wa};
  endfunction

  task automatic wr_s(input logic [AW-1:0] a, input logic [15:0] d,
                      input logic c, input logic w, input logic o);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(negedge clk);
    s_pg = pg_go; s_er = er_go; s_all = er_all; s_sus = sus_go; s_res = res_go;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-2:0] wa, input logic [15:0] d);
    wr_s(phys(wa), d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic unl();
    wr(22'h555, 16'hAA); wr(22'h2AA, 16'h55);
  endtask

  task automatic hreset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12 mode", mode, 0); chk("R12 sec", sec_on, 0);
    chk("R12 byp", byp_act, 0); chk("R12 pulse", pg_go | er_go, 0);

    // R1: every strobe combination on the final program write
    for (int c = 0; c < 8; c++) begin
      hreset();
      unl(); wr(22'h555, 16'hA0);
      wr_s(23'h1234, 16'hBEEF, c[2], c[1], c[0]);
      chk("R1 strobe", s_pg, (c == 1) ? 1 : 0);
    end

    // R2: program in word and byte addressing
    for (int bm = 0; bm < 2; bm++) begin
      for (int k = 0; k < 3; k++) begin
        logic [AW-2:0] wa;
        hreset();
        byte_mode = bm[0];
        wa = 22'(22'h00F00 * (k + 1) + k);
        unl(); wr(22'h555, 16'hA0); wr(wa, 16'(16'h1111 * (k + 1)));
        chk("R2 go", s_pg, 1);
        chk("R2 addr", op_addr, phys(wa));
        chk("R2 data", op_data, 16'h1111 * (k + 1));
      end
    end
    byte_mode = 1'b0;

    // R3 / R4: query entry, ignore, exit; from identify mode
    hreset();
    wr(22'h055, 16'h98); chk("R3 enter", mode, 2);
    unl(); wr(22'h555, 16'hA0); wr(22'h10, 16'h1);
    chk("R3 ignored", s_pg, 0); chk("R3 stay", mode, 2);
    wr(22'h0, 16'hF0); chk("R3 exit", mode, 0);
    unl(); wr(22'h555, 16'h90); chk("R4 enter", mode, 1);
    wr(22'h055, 16'h98); chk("R3 from identify", mode, 2);
    wr(22'h0, 16'hF0);
    unl(); wr(22'h555, 16'h90); wr(22'h0, 16'hF0); chk("R4 exit", mode, 0);
    byte_mode = 1'b1;
    wr(22'h055, 16'h98); chk("R3 byte addr", mode, 2);
    wr(22'h0, 16'hF0); byte_mode = 1'b0;

    // R3 / R10: writes during busy are dropped
    @(negedge clk); busy = 1'b1;
    wr(22'h055, 16'h98); chk("R3 busy", mode, 0);
    unl(); wr(22'h555, 16'hA0); wr(22'h20, 16'h5);
    chk("R10 busy ignore", s_pg, 0);
    @(negedge clk); busy = 1'b0; @(negedge clk);
    wr(22'h20, 16'h5); chk("R10 no stale seq", s_pg, 0);

    // R10: completion returns to array mode from identify
    unl(); wr(22'h555, 16'h90);
    @(negedge clk); busy = 1'b1; @(negedge clk); busy = 1'b0;
    @(negedge clk); chk("R10 done read", mode, 0);

    // R5 / R9: sector erase, suspend, resume; chip erase
    hreset();
    unl(); wr(22'h555, 16'h80); unl(); wr(22'h3F000, 16'h30);
    chk("R5 sector go", s_er, 1); chk("R5 sector all", s_all, 0);
    chk("R5 sector addr", op_addr, 23'h3F000);
    @(negedge clk); busy = 1'b1;
    wr(22'h0, 16'hB0); chk("R9 suspend", s_sus, 1);
    @(negedge clk); busy = 1'b0;
    wr(22'h0, 16'h30); chk("R9 resume", s_res, 1);
    @(negedge clk); busy = 1'b1; @(negedge clk); busy = 1'b0; @(negedge clk);
    wr(22'h0, 16'h30); chk("R9 no resume", s_res, 0);
    unl(); wr(22'h555, 16'h80); unl(); wr(22'h555, 16'h10);
    chk("R5 chip go", s_er, 1); chk("R5 chip all", s_all, 1);
    @(negedge clk); busy = 1'b1; @(negedge clk); busy = 1'b0; @(negedge clk);
    unl(); wr(22'h555, 16'hA0); wr(22'h40, 16'h7);
    @(negedge clk); busy = 1'b1;
    wr(22'h0, 16'hB0); chk("R9 no suspend on program", s_sus, 0);
    @(negedge clk); busy = 1'b0; @(negedge clk);

    // R6: fast program mode and acceleration
    hreset();
    unl(); wr(22'h555, 16'h20); chk("R6 enter", byp_act, 1);
    wr(22'h0, 16'hA0); wr(22'h777, 16'h4242);
    chk("R6 two-cycle go", s_pg, 1); chk("R6 data", op_data, 16'h4242);
    wr(22'h0, 16'h90); wr(22'h0, 16'h00); chk("R6 exit", byp_act, 0);
    acc_req = 1'b1; @(negedge clk);
    chk("R6 acc byp", byp_act, 1); chk("R6 acc en", acc_en, 1);
    acc_req = 1'b0;

    // R7: overlay entry, region sweep, exclusions, exit
    hreset();
    unl(); wr(22'h555, 16'h88); chk("R7 enter", sec_on, 1);
    for (int w = 0; w < 300; w++) begin
      addr = phys(22'(w)); #1;
      chk("R7 region", region_sel, (w < 128) ? 1 : 0);
    end
    acc_req = 1'b1; @(negedge clk);
    chk("R7 no acc", acc_en, 0); chk("R7 no byp acc", byp_act, 0);
    acc_req = 1'b0;
    unl(); wr(22'h555, 16'h20); chk("R7 byp blocked", byp_act, 0);

    // R8: lock verify
    lock_in = 1'b1;
    wr(22'h0, 16'h60); wr(22'h002, 16'h40); chk("R8 enter", mode, 3);
    addr = 23'h002; #1; chk("R8 locked", vfy_q, 8'h01);
    lock_in = 1'b0; #1; chk("R8 unlocked", vfy_q, 8'h00);
    lock_in = 1'b1; addr = 23'h042; #1; chk("R8 A6 high", vfy_q, 8'h00);
    wr(22'h0, 16'hF0); chk("R8 exit", mode, 0);
    wr(22'h0, 16'h60); wr(22'h003, 16'h40); chk("R8 bad addr", mode, 0);
    unl(); wr(22'h555, 16'h90); wr(22'h0, 16'h00);
    chk("R7 exit", sec_on, 0);
    addr = 23'h0; #1; chk("R7 region off", region_sel, 0);

    // R11: broken sequences
    unl(); wr(22'h555, 16'h90);
    wr(22'h123, 16'h77); chk("R11 stray from identify", mode, 0);
    wr(22'h555, 16'hAA); wr(22'h2AB, 16'h55);
    wr(22'h555, 16'hA0); wr(22'h50, 16'h9);
    chk("R11 abort", s_pg, 0);

    // R12: reset drops partial sequence and overlay
    unl(); wr(22'h555, 16'hA0);
    hreset();
    wr(22'h60, 16'h3); chk("R12 partial dropped", s_pg, 0);
    unl(); wr(22'h555, 16'h88);
    hreset();
    chk("R12 overlay cleared", sec_on, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule